// File: doc/BRIEF.md
# Slow-Control Request Frame Processor

This block turns one slow-control request, presented as a stream of 32-bit words, into accesses on a simple internal register bus. It then streams back a reply. A request starts with four header words: an identifier, a location word, a command word and an argument word. Data words follow, and the last word of the frame is flagged. The block keeps the header in registers and puts the data words in a small buffer. Once the frame has ended, it checks the header and decides between two paths: carry out the access sequence, or reject the frame.

The command word packs three fields: an access code in bits 31:24, an access type in bits 23:16 and a length field in bits 15:0, which must read 0xFFFF. Four code/type pairs are accepted:

| Code | Type | Access | How the data words are used | Register address |
|------|------|--------|-----------------------------|------------------|
| 0xAA | 0xAA | Paired write | Address/value pairs | From each pair |
| 0xAA | 0xBB | Block write | Values to write | Argument word, then counting up |
| 0xBB | 0xBB | Block read | Placeholders, one read each | Argument word, then counting up |
| 0xBB | 0xAA | Listed read | Addresses to read | From each word |

A good reply is built as follows:

- The identifier, with bit 31 cleared.
- The other three header words, copied unchanged.
- For each access, a status word of 0 followed by the value that was written or read.

A rejected frame gets a different reply. It echoes the header words that were received, with bit 31 of the identifier cleared, then ends with one error word. A rejected frame causes no bus access.

Top module: `sc_frame_proc`

## Requirements
- R1: A good reply starts with the identifier with bit 31 cleared, followed by the location, command and argument words unchanged. `out_last` marks the final reply word, which is the argument word when there are no accesses.
- R2: Paired write (code 0xAA, type 0xAA) takes the data words in pairs: first an address, then a value. It writes each value to the low `ADDR_W` bits of its address and replies 0 then the value for each pair.
- R3: Block write (code 0xAA, type 0xBB) writes data word k to address (argument + k) modulo 2^`ADDR_W`. It replies 0 then the written value for each word. Up to `DEPTH` data words are accepted.
- R4: Block read (code 0xBB, type 0xBB) performs one read per data word, from address (argument + k) modulo 2^`ADDR_W`. It replies 0 then the value read. `reg_rdata` is sampled in the cycle after the one in which `reg_re` is high.
- R5: Listed read (code 0xBB, type 0xAA) reads from the low `ADDR_W` bits of each data word, in order, and replies 0 then the value read.
- R6: A frame of fewer than 4 words gets this reply: the received words, with bit 31 of the first one cleared, then the error word 0x08000000.
- R7: If bit 31 of the identifier is clear, bit 26 of the error word is set.
- R8: A code/type pair not among the four listed sets bit 19 of the error word.
- R9: Bit 18 of the error word flags a malformed command. This covers a length field other than 0xFFFF, a paired write with an odd number of data words, and more than `DEPTH` data words. When several conditions apply, all their bits are set in one error word.
- R10: A frame that gets an error reply drives no `reg_we` and no `reg_re`. The register contents therefore stay unchanged.
- R11: `in_ready` falls after the final word of a frame and stays low until the reply has been sent. `reg_we` and `reg_re` are single-cycle pulses and are never high together.
- R12: During and just after reset, `in_ready` is 1 and `out_valid`, `reg_we` and `reg_re` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request word present |
| in_data | input | 32 | Request word |
| in_last | input | 1 | Final word of the request |
| in_ready | output | 1 | Block accepts a request word this cycle |
| out_valid | output | 1 | Reply word present |
| out_data | output | 32 | Reply word |
| out_last | output | 1 | Final word of the reply |
| reg_addr | output | ADDR_W | Register bus address |
| reg_wdata | output | 32 | Register bus write value |
| reg_we | output | 1 | Register write strobe |
| reg_re | output | 1 | Register read strobe |
| reg_rdata | input | 32 | Read value, valid the cycle after `reg_re` |

## Verification
The bench targets the following corner cases:

- **Address wrap in a block read.** A read starting at the top of the address space must continue at zero. A design that carried the increment beyond `ADDR_W` bits would read the wrong registers.
- **Paired write with an odd count.** A design that checked the count only after starting the writes would change a register that a later listed read shows as untouched.
- **Full buffer.** A frame that exactly fills the buffer must run normally, and a frame one word longer must be rejected. Getting this wrong gives either a lost last word or a missing bit 18.
- **Short and combined-error frames.** A frame of one, two or three words exercises the partial header echo. A frame with several faults at once must show every applicable error bit, not only the first one found.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [1:0] {
    OP_WPAIR  = 2'd0,
    OP_WBURST = 2'd1,
    OP_RBURST = 2'd2,
    OP_RLIST  = 2'd3
  } sc_op_e;

  localparam int ERR_SHORT = 27;
  localparam int ERR_ID    = 26;
  localparam int ERR_UNK   = 19;
  localparam int ERR_MAL   = 18;

  localparam logic [7:0]  CODE_A  = 8'hAA;
  localparam logic [7:0]  CODE_B  = 8'hBB;
  localparam logic [15:0] LEN_RSV = 16'hFFFF;
endpackage

// File: rtl/sc_word_ram.sv
module sc_word_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sc_rx_frame.sv
module sc_rx_frame
  import sc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 5),
  parameter int NW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [31:0]      in_data,
  input  logic             in_last,
  output logic             in_ready,
  output logic             ram_we,
  output logic [AW-1:0]    ram_waddr,
  output logic [31:0]      ram_wdata,
  input  logic             exec_done,
  output logic             start,
  output logic [3:0][31:0] hdr,
  output logic [2:0]       hdr_cnt,
  output logic [31:0]      err_word,
  output sc_op_e           op,
  output logic [NW-1:0]    nacc
);
  typedef enum logic [1:0] {RX_IDLE, RX_CHK, RX_WAIT} rx_st_e;

  rx_st_e           st;
  logic [CNT_W-1:0] wcnt;
  logic             ovf;
  logic             accept, full, short_f, known;
  logic [CNT_W-1:0] ndata;
  sc_op_e           op_c;
  logic [31:0]      err_c;
  logic [NW-1:0]    nacc_c;

  assign in_ready  = (st == RX_IDLE);
  assign accept    = in_valid && in_ready;
  assign full      = (wcnt == CNT_W'(DEPTH + 4));
  assign ram_we    = accept && (wcnt >= CNT_W'(4)) && !full;
  assign ram_waddr = AW'(wcnt - CNT_W'(4));
  assign ram_wdata = in_data;

  // header check, evaluated once the whole frame is in
  always_comb begin
    short_f = (wcnt < CNT_W'(4));
    ndata   = wcnt - CNT_W'(4);
    known   = 1'b1;
    op_c    = OP_WPAIR;
    case ({hdr[2][31:24], hdr[2][23:16]})
      {CODE_A, CODE_A}: op_c = OP_WPAIR;
      {CODE_A, CODE_B}: op_c = OP_WBURST;
      {CODE_B, CODE_B}: op_c = OP_RBURST;
      {CODE_B, CODE_A}: op_c = OP_RLIST;
      default:          known = 1'b0;
    endcase
    err_c = '0;
    if (short_f) begin
      err_c[ERR_SHORT] = 1'b1;
    end else begin
      err_c[ERR_ID]  = !hdr[0][31];
      err_c[ERR_UNK] = !known;
      err_c[ERR_MAL] = (hdr[2][15:0] != LEN_RSV) || ovf ||
                       (known && (op_c == OP_WPAIR) && ndata[0]);
    end
    nacc_c = (op_c == OP_WPAIR) ? NW'(ndata >> 1) : NW'(ndata);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= RX_IDLE;
      wcnt     <= '0;
      ovf      <= 1'b0;
      start    <= 1'b0;
      hdr      <= '0;
      hdr_cnt  <= '0;
      err_word <= '0;
      op       <= OP_WPAIR;
      nacc     <= '0;
    end else begin
      start <= 1'b0;
      case (st)
        RX_IDLE: begin
          if (accept) begin
            if (wcnt < CNT_W'(4)) hdr[wcnt[1:0]] <= in_data;
            if (full) ovf  <= 1'b1;
            else      wcnt <= wcnt + 1'b1;
            if (in_last) st <= RX_CHK;
          end
        end
        RX_CHK: begin
          start    <= 1'b1;
          err_word <= err_c;
          op       <= op_c;
          nacc     <= nacc_c;
          hdr_cnt  <= short_f ? wcnt[2:0] : 3'd4;
          wcnt     <= '0;
          ovf      <= 1'b0;
          st       <= RX_WAIT;
        end
        default: begin
          if (exec_done) st <= RX_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/sc_exec.sv
module sc_exec
  import sc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int AW     = 4,
  parameter int NW     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  sc_op_e            op,
  input  logic [31:0]       err_word,
  input  logic [3:0][31:0]  hdr,
  input  logic [2:0]        hdr_cnt,
  input  logic [NW-1:0]     nacc,
  output logic [AW-1:0]     ram_raddr,
  input  logic [31:0]       ram_q,
  output logic              out_valid,
  output logic [31:0]       out_data,
  output logic              out_last,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [31:0]       reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [31:0]       reg_rdata,
  output logic              done
);
  typedef enum logic [3:0] {
    X_IDLE, X_HDR, X_ERR, X_DONE, X_NEXT, X_FETCH, X_FETCH2,
    X_BUS, X_RDW, X_EMITE, X_EMITD
  } x_st_e;

  x_st_e             st;
  logic [2:0]        idx;
  logic [AW-1:0]     ptr;
  logic [NW-1:0]     left;
  logic [ADDR_W-1:0] base, cur_addr;
  logic [31:0]       cur_val;
  logic              is_wr;

  assign ram_raddr = ptr;
  assign is_wr     = (op == OP_WPAIR) || (op == OP_WBURST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= X_IDLE;
      idx       <= '0;
      ptr       <= '0;
      left      <= '0;
      base      <= '0;
      cur_addr  <= '0;
      cur_val   <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
      done      <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
      done      <= 1'b0;
      case (st)
        X_IDLE: if (start) begin
          idx  <= '0;
          ptr  <= '0;
          left <= nacc;
          base <= hdr[3][ADDR_W-1:0];
          st   <= X_HDR;
        end
        X_HDR: begin
          out_valid <= 1'b1;
          out_data  <= (idx == 3'd0) ? (hdr[0] & 32'h7FFF_FFFF) : hdr[idx[1:0]];
          idx       <= idx + 3'd1;
          if (idx + 3'd1 == hdr_cnt) begin
            if (err_word != '0) st <= X_ERR;
            else if (left == '0) begin
              out_last <= 1'b1;
              st       <= X_DONE;
            end else st <= X_NEXT;
          end
        end
        X_ERR: begin
          out_valid <= 1'b1;
          out_data  <= err_word;
          out_last  <= 1'b1;
          st        <= X_DONE;
        end
        X_DONE: begin
          done <= 1'b1;
          st   <= X_IDLE;
        end
        X_NEXT: begin
          if (op == OP_RBURST) begin
            reg_addr <= base;
            reg_re   <= 1'b1;
            base     <= base + 1'b1;
            st       <= X_BUS;
          end else begin
            ptr <= ptr + 1'b1;
            st  <= X_FETCH;
          end
        end
        X_FETCH: begin
          case (op)
            OP_WPAIR: begin
              cur_addr <= ram_q[ADDR_W-1:0];
              ptr      <= ptr + 1'b1;
              st       <= X_FETCH2;
            end
            OP_WBURST: begin
              reg_addr  <= base;
              reg_wdata <= ram_q;
              reg_we    <= 1'b1;
              cur_val   <= ram_q;
              base      <= base + 1'b1;
              st        <= X_BUS;
            end
            default: begin
              reg_addr <= ram_q[ADDR_W-1:0];
              reg_re   <= 1'b1;
              st       <= X_BUS;
            end
          endcase
        end
        X_FETCH2: begin
          reg_addr  <= cur_addr;
          reg_wdata <= ram_q;
          reg_we    <= 1'b1;
          cur_val   <= ram_q;
          st        <= X_BUS;
        end
        X_BUS: st <= is_wr ? X_EMITE : X_RDW;
        X_RDW: begin
          cur_val <= reg_rdata;
          st      <= X_EMITE;
        end
        X_EMITE: begin
          out_valid <= 1'b1;
          out_data  <= '0;
          st        <= X_EMITD;
        end
        X_EMITD: begin
          out_valid <= 1'b1;
          out_data  <= cur_val;
          left      <= left - 1'b1;
          if (left == NW'(1)) begin
            out_last <= 1'b1;
            st       <= X_DONE;
          end else st <= X_NEXT;
        end
        default: st <= X_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sc_frame_proc.sv
module sc_frame_proc
  import sc_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              out_valid,
  output logic [31:0]       out_data,
  output logic              out_last,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [31:0]       reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [31:0]       reg_rdata
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 5);
  localparam int NW    = $clog2(DEPTH + 1);

  logic             ram_we;
  logic [AW-1:0]    ram_waddr, ram_raddr;
  logic [31:0]      ram_wdata, ram_q;
  logic             start, exec_done;
  logic [3:0][31:0] hdr;
  logic [2:0]       hdr_cnt;
  logic [31:0]      err_word;
  sc_op_e           op;
  logic [NW-1:0]    nacc;

  sc_rx_frame #(.DEPTH(DEPTH), .AW(AW), .CNT_W(CNT_W), .NW(NW)) rx_i (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .exec_done(exec_done), .start(start), .hdr(hdr), .hdr_cnt(hdr_cnt),
    .err_word(err_word), .op(op), .nacc(nacc)
  );

  sc_word_ram #(.W(32), .DEPTH(DEPTH), .AW(AW)) buf_i (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_q)
  );

  sc_exec #(.ADDR_W(ADDR_W), .AW(AW), .NW(NW)) ex_i (
    .clk(clk), .rst(rst), .start(start), .op(op), .err_word(err_word),
    .hdr(hdr), .hdr_cnt(hdr_cnt), .nacc(nacc),
    .ram_raddr(ram_raddr), .ram_q(ram_q),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
    .reg_rdata(reg_rdata), .done(exec_done)
  );
endmodule

// File: rtl/sc_frame_proc_chk.sv
module sc_frame_proc_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_last,
  input logic in_ready,
  input logic out_valid,
  input logic out_last,
  input logic reg_we,
  input logic reg_re
);
  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_re));

  // R11
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we || reg_re) |=> !(reg_we || reg_re));

  // R11
  hold_off_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |=> !in_ready);

  // R11
  bus_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we || reg_re) |-> !in_ready);

  // R11
  reply_busy_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  // R1
  last_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  // R4
  rd_gap_chk: assert property (@(posedge clk) disable iff (rst)
    reg_re |=> !out_valid);
endmodule

bind sc_frame_proc sc_frame_proc_chk chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
  .in_ready(in_ready), .out_valid(out_valid), .out_last(out_last),
  .reg_we(reg_we), .reg_re(reg_re)
);

// File: tb/sc_frame_proc_tb.sv
`timescale 1ns/1ps
module sc_frame_proc_tb_top;
  localparam int DEPTH = 16;
  localparam logic [31:0] C_WPAIR  = 32'hAAAA_FFFF;
  localparam logic [31:0] C_WBURST = 32'hAABB_FFFF;
  localparam logic [31:0] C_RBURST = 32'hBBBB_FFFF;
  localparam logic [31:0] C_RLIST  = 32'hBBAA_FFFF;

  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic in_valid = 1'b0, in_last = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid, out_last, reg_we, reg_re;
  logic [31:0] out_data, reg_wdata;
  logic [31:0] reg_rdata = '0;
  logic [7:0] reg_addr;

  sc_frame_proc #(.DEPTH(DEPTH), .ADDR_W(8)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
    .reg_rdata(reg_rdata)
  );

  int checks = 0, errors = 0;
  string cur_req = "R12";
  logic [31:0] dev_mem [256];
  logic [31:0] mdl_mem [256];
  logic [32:0] exp_out [$];
  logic [40:0] exp_op [$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // register device and per-cycle comparison against the reference queues
  always @(negedge clk) begin
    if (!rst) begin
      if (reg_re) reg_rdata = dev_mem[reg_addr];
      if (reg_we || reg_re) begin
        if (exp_op.size() == 0) begin
          check(1'b0, "R10", "unexpected bus access addr", {24'd0, reg_addr}, 32'hFFFF_FFFF);
        end else begin
          logic [40:0] e;
          e = exp_op.pop_front();
          check(reg_we == e[40], cur_req, "access kind", {31'd0, reg_we}, {31'd0, e[40]});
          check(reg_addr == e[39:32], cur_req, "access addr", {24'd0, reg_addr}, {24'd0, e[39:32]});
          if (reg_we) check(reg_wdata == e[31:0], cur_req, "write value", reg_wdata, e[31:0]);
        end
        if (reg_we) dev_mem[reg_addr] = reg_wdata;
      end
      if (out_valid) begin
        check(!in_ready, "R11", "in_ready during reply", {31'd0, in_ready}, 32'd0);
        if (exp_out.size() == 0) begin
          check(1'b0, cur_req, "unexpected reply word", out_data, 32'hFFFF_FFFF);
        end else begin
          logic [32:0] e;
          e = exp_out.pop_front();
          check(out_data == e[31:0], cur_req, "reply word", out_data, e[31:0]);
          check(out_last == e[32], cur_req, "reply last flag", {31'd0, out_last}, {31'd0, e[32]});
        end
      end
    end
  end

  task automatic push_out(input logic [31:0] d, input bit last);
    exp_out.push_back({last, d});
  endtask

  task automatic model_frame(input logic [31:0] w[$]);
    int n = w.size();
    int md, nd, nacc;
    logic [31:0] e;
    logic [7:0] a;
    if (n < 4) begin
      for (int i = 0; i < n; i++) push_out(i == 0 ? (w[i] & 32'h7FFF_FFFF) : w[i], 1'b0);
      push_out(32'h0800_0000, 1'b1);
      return;
    end
    md = -1;
    case ({w[2][31:24], w[2][23:16]})
      16'hAAAA: md = 0;
      16'hAABB: md = 1;
      16'hBBBB: md = 2;
      16'hBBAA: md = 3;
      default:  md = -1;
    endcase
    nd = n - 4;
    e = '0;
    if (!w[0][31]) e[26] = 1'b1;
    if (md < 0) e[19] = 1'b1;
    if (w[2][15:0] != 16'hFFFF || nd > DEPTH || (md == 0 && (nd % 2) == 1)) e[18] = 1'b1;
    nacc = (md == 0) ? nd / 2 : nd;
    for (int i = 0; i < 4; i++)
      push_out(i == 0 ? (w[0] & 32'h7FFF_FFFF) : w[i], (e == 0) && (nacc == 0) && (i == 3));
    if (e != 0) begin
      push_out(e, 1'b1);
      return;
    end
    for (int k = 0; k < nacc; k++) begin
      case (md)
        0: begin a = w[4 + 2*k][7:0]; mdl_mem[a] = w[5 + 2*k]; exp_op.push_back({1'b1, a, mdl_mem[a]}); end
        1: begin a = w[3][7:0] + 8'(k); mdl_mem[a] = w[4 + k];  exp_op.push_back({1'b1, a, mdl_mem[a]}); end
        2: begin a = w[3][7:0] + 8'(k); exp_op.push_back({1'b0, a, mdl_mem[a]}); end
        default: begin a = w[4 + k][7:0]; exp_op.push_back({1'b0, a, mdl_mem[a]}); end
      endcase
      push_out(32'd0, 1'b0);
      push_out(mdl_mem[a], k == nacc - 1);
    end
  endtask

  task automatic run_frame(input string req, input logic [31:0] w[$]);
    int guard = 0;
    cur_req = req;
    model_frame(w);
    for (int i = 0; i < w.size(); i++) begin
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_data  = w[i];
      in_last  = (i == w.size() - 1);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    while ((exp_out.size() != 0 || !in_ready) && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    check(exp_out.size() == 0, req, "reply words missing", exp_out.size(), 0);
    check(exp_op.size() == 0, req, "bus accesses missing", exp_op.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] f[$];
    for (int i = 0; i < 256; i++) begin
      dev_mem[i] = (i * 32'h0101_0101) ^ 32'hC300_0000;
      mdl_mem[i] = dev_mem[i];
    end
    repeat (3) @(negedge clk);
    // R12 reset state
    check(in_ready == 1'b1, "R12", "in_ready in reset", {31'd0, in_ready}, 1);
    check(!out_valid && !reg_we && !reg_re, "R12", "outputs in reset",
          {29'd0, out_valid, reg_we, reg_re}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready && !out_valid && !reg_we && !reg_re, "R12", "state after reset",
          {28'd0, in_ready, out_valid, reg_we, reg_re}, 32'h8);

    // R1 R2 paired write, one address truncated to ADDR_W bits
    f = '{32'h8000_1234, 32'h0000_00A5, C_WPAIR, 32'h0, 32'h3, 32'h1111_0001,
          32'h7, 32'h2222_0002, 32'h1FE, 32'h3333_0003};
    run_frame("R2", f);
    // R1 paired write with no data: header-only reply
    f = '{32'h8765_4321, 32'h0000_0003, C_WPAIR, 32'h0};
    run_frame("R1", f);
    // R3 block write
    f = '{32'h8000_0002, 32'h5, C_WBURST, 32'h20, 32'hA0, 32'hA1, 32'hA2, 32'hA3};
    run_frame("R3", f);
    // R4 block read
    f = '{32'h8000_0003, 32'h6, C_RBURST, 32'h1E, 0, 0, 0, 0, 0};
    run_frame("R4", f);
    // R4 address wrap
    f = '{32'hFFFF_FFFF, 32'h6, C_RBURST, 32'hFE, 0, 0, 0};
    run_frame("R4", f);
    // R5 listed read
    f = '{32'h8000_0005, 32'h9, C_RLIST, 32'h0, 32'h3, 32'h7, 32'hFE, 32'h123, 32'h42};
    run_frame("R5", f);
    // R6 short frames
    f = '{32'h8000_0001};
    run_frame("R6", f);
    f = '{32'h8000_0001, 32'h44};
    run_frame("R6", f);
    f = '{32'h0000_0001, 32'h44, C_WPAIR};
    run_frame("R6", f);
    // R7 identifier without bit 31
    f = '{32'h0000_0055, 32'h1, C_WPAIR, 32'h0, 32'h60, 32'hDEAD_BEEF};
    run_frame("R7", f);
    // R8 unknown code/type pairs
    f = '{32'h8000_0010, 32'h1, 32'hAACC_FFFF, 32'h0, 32'h61};
    run_frame("R8", f);
    f = '{32'h8000_0011, 32'h1, 32'hCCAA_FFFF, 32'h0};
    run_frame("R8", f);
    // R9 bad length field
    f = '{32'h8000_0012, 32'h1, 32'hAABB_0000, 32'h62, 32'h1};
    run_frame("R9", f);
    // R9 odd paired write, then R10 read back untouched register
    f = '{32'h8000_0013, 32'h1, C_WPAIR, 32'h0, 32'h50, 32'h5555_5555, 32'h51};
    run_frame("R9", f);
    f = '{32'h8000_0014, 32'h1, C_RLIST, 32'h0, 32'h50, 32'h51, 32'h60};
    run_frame("R10", f);
    // R9 combined faults
    f = '{32'h0000_0015, 32'h1, 32'hCCCC_0001, 32'h0};
    run_frame("R9", f);
    // R3 buffer exactly full, then R9 one word too many
    f = '{32'h8000_0016, 32'h2, C_WBURST, 32'h80};
    for (int i = 0; i < DEPTH; i++) f.push_back(32'h7700_0000 + i);
    run_frame("R3", f);
    f = '{32'h8000_0017, 32'h2, C_WBURST, 32'h90};
    for (int i = 0; i <= DEPTH; i++) f.push_back(32'h6600_0000 + i);
    run_frame("R9", f);
    f = '{32'h8000_0018, 32'h2, C_RBURST, 32'h80};
    for (int i = 0; i < DEPTH + 2; i++) f.push_back(32'h0);
    run_frame("R9", f);
    f = '{32'h8000_0019, 32'h2, C_RBURST, 32'h80};
    for (int i = 0; i < DEPTH; i++) f.push_back(32'h0);
    run_frame("R4", f);
    f = '{32'h8000_001A, 32'h2, C_RLIST, 32'h0, 32'h90, 32'h9F};
    run_frame("R10", f);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule